// File: doc/BRIEF.md
# CAN Transmit Mailbox Register Bank

This block holds thirty-two transmit mailboxes for a CAN controller. Software reaches them through a simple word-addressed register port. Each mailbox has four words:

- a control word, whose bit 0 is the transmit-request flag;
- an identifier word;
- a high data word;
- a low data word.

Setting the request flag marks the mailbox as ready to send. All request flags are gathered into one vector for the transmit engine. The engine reads the identifier and the eight payload bytes of any mailbox through a side port that always presents bytes in canonical order.

When the engine finishes a frame, it returns a one-cycle completion pulse with a mailbox index, and that mailbox's flag drops. While a flag is up, the identifier and payload of that mailbox are frozen, and software writes to them are dropped. A configuration input selects whether each 32-bit data word maps its bytes most-significant-first or reversed. The mapping applies to both software writes and software reads.

Top module: `can_txbox_bank`

## Requirements
- R1: The bank holds NBUF (32) mailboxes. The register address is {mailbox index, word select}, with word select 0 for control, 1 for identifier, 2 for high data and 3 for low data. At most one request flag can rise per cycle.
- R2: A write to a control word with wdata[0]=1 sets that mailbox's request flag at the next clock edge. The flag then shows in req_vec[index] and in bit 0 of the control word read.
- R3: A control write with wdata[0]=0 leaves the flag unchanged. Control word bits [31:1] always read 0.
- R4: While a mailbox's flag is 1, writes to its identifier and data words are ignored. Writes to other mailboxes still take effect.
- R5: The identifier word stores a 29-bit identifier from wdata[31:3]. Bits [2:0] read 0 whatever was written.
- R6: With cfg_swap=0, the high data word carries payload bytes 1,2,3,4 in bits [31:24],[23:16],[15:8],[7:0]. The low word carries bytes 5,6,7,8 in the same lanes.
- R7: With cfg_swap=1, the lane order inside each data word is reversed. The high word carries bytes 4,3,2,1 and the low word bytes 8,7,6,5, from [31:24] down to [7:0], for both writes and reads.
- R8: After reset, every flag, identifier and payload byte is 0 and req_vec is 0.
- R9: A completion pulse (done_valid=1, done_idx=i) clears flag i at the next edge. If a control write of 1 to mailbox i occurs in the same cycle, the completion wins and the flag ends up 0.
- R10: A completion for a mailbox whose flag is 0 changes nothing. A completion for mailbox i leaves every other flag unchanged.
- R11: eng_id and eng_data show the identifier and payload of mailbox eng_idx combinationally. Byte 1 is in eng_data[63:56] and byte 8 in eng_data[7:0], whatever cfg_swap is.
- R12: rdata shows the addressed word combinationally in the same cycle as rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_swap | input | 1 | Data word byte-lane reversal select |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Write address {index, word select} |
| wdata | input | 32 | Write data |
| rd_addr | input | 7 | Read address {index, word select} |
| rdata | output | 32 | Read data |
| done_valid | input | 1 | Transmit completion pulse |
| done_idx | input | 5 | Mailbox index of the completion |
| req_vec | output | 32 | Request flags of all mailboxes |
| eng_idx | input | 5 | Mailbox selected by the transmit engine |
| eng_id | output | 29 | Identifier of the selected mailbox |
| eng_data | output | 64 | Payload of the selected mailbox, byte 1 at the top |

## Verification
The bench attacks the collision of a completion pulse with a software set of the same mailbox. A design that let the write win would leave a stale request that retransmits a frame. It writes identifier and data words into a pending mailbox and checks that the payload is frozen, since a missing lock would corrupt a frame in flight. It also writes a payload under one swap setting and reads it under the other, while checking the engine port. A design that stored the bus image raw would hand the engine reversed bytes. Completions aimed at idle mailboxes are sent too, so that a decoder spilling into neighbouring flags or setting a flag would show up at once in req_vec.

// File: rtl/can_txbox_pkg.sv
package can_txbox_pkg;
  typedef enum logic [1:0] {
    WSEL_CTL = 2'd0,
    WSEL_ID  = 2'd1,
    WSEL_DHI = 2'd2,
    WSEL_DLO = 2'd3
  } word_sel_e;

  localparam int ID_BITS = 29;

  // Lane reversal between bus image and canonical order (self-inverse).
  function automatic logic [31:0] lane_map(input logic [31:0] w, input logic swap);
    return swap ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  // Identifier word image: identifier on top, reserved bits zero.
  function automatic logic [31:0] id_image(input logic [ID_BITS-1:0] id);
    return {id, 3'b000};
  endfunction
endpackage

// File: rtl/can_txbox_slot.sv
module can_txbox_slot
  import can_txbox_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_hit,
  input  word_sel_e          word_sel,
  input  logic [31:0]        wdata,
  input  logic               swap,
  input  logic               done_hit,
  output logic               req_o,
  output logic [ID_BITS-1:0] id_o,
  output logic [63:0]        data_o
);
  logic               req_q;
  logic [ID_BITS-1:0] id_q;
  logic [63:0]        data_q;

  // Named internal events
  logic set_req;
  logic clr_req;
  logic body_wr;
  logic lock_drop;

  assign set_req   = wr_hit && (word_sel == WSEL_CTL) && wdata[0] && !done_hit;
  assign clr_req   = done_hit && req_q;
  assign body_wr   = wr_hit && (word_sel != WSEL_CTL) && !req_q;
  assign lock_drop = wr_hit && (word_sel != WSEL_CTL) && req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (clr_req) begin
      req_q <= 1'b0;
    end else if (set_req) begin
      req_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      data_q <= '0;
    end else if (body_wr) begin
      case (word_sel)
        WSEL_ID:  id_q           <= wdata[31:3];
        WSEL_DHI: data_q[63:32]  <= lane_map(wdata, swap);
        WSEL_DLO: data_q[31:0]   <= lane_map(wdata, swap);
        default:  ;
      endcase
    end
  end

  assign req_o  = req_q;
  assign id_o   = id_q;
  assign data_o = data_q;

  // R4: contents frozen while pending
  a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> ($stable(id_q) && $stable(data_q)));
  // R4: a dropped write leaves the contents as they were
  a_r4_drop_nochange: assert property (@(posedge clk) disable iff (!rst_n)
    lock_drop |=> $stable(data_q));
  // R2: a set without a completion raises the flag
  a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && word_sel == WSEL_CTL && wdata[0] && !done_hit) |=> req_q);
  // R9: completion always leaves the flag low
  a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> !req_q);
  // R3: control write of zero never raises the flag
  a_r3_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && word_sel == WSEL_CTL && !wdata[0] && !done_hit) |=> (req_q == $past(req_q)));
endmodule

// File: rtl/can_txbox_rdmux.sv
module can_txbox_rdmux
  import can_txbox_pkg::*;
#(
  parameter int NBUF = 32,
  localparam int IDXW = $clog2(NBUF),
  localparam int AW   = IDXW + 2
) (
  input  logic [NBUF-1:0]              req,
  input  logic [NBUF-1:0][ID_BITS-1:0] ids,
  input  logic [NBUF-1:0][63:0]        datas,
  input  logic                         swap,
  input  logic [AW-1:0]                rd_addr,
  input  logic [IDXW-1:0]              eng_idx,
  output logic [31:0]                  rdata,
  output logic [ID_BITS-1:0]           eng_id,
  output logic [63:0]                  eng_data
);
  logic [IDXW-1:0] rd_idx;
  word_sel_e       rd_sel;

  assign rd_idx = rd_addr[AW-1:2];
  assign rd_sel = word_sel_e'(rd_addr[1:0]);

  always_comb begin
    case (rd_sel)
      WSEL_CTL: rdata = {31'b0, req[rd_idx]};
      WSEL_ID:  rdata = id_image(ids[rd_idx]);
      WSEL_DHI: rdata = lane_map(datas[rd_idx][63:32], swap);
      default:  rdata = lane_map(datas[rd_idx][31:0], swap);
    endcase
  end

  assign eng_id   = ids[eng_idx];
  assign eng_data = datas[eng_idx];

  // R5: reserved identifier bits never read as 1
  always_comb begin
    if (rd_sel == WSEL_ID)
      a_r5_reserved_zero: assert (rdata[2:0] == 3'b000);
  end
endmodule

// File: rtl/can_txbox_bank.sv
module can_txbox_bank
  import can_txbox_pkg::*;
#(
  parameter int NBUF = 32,
  localparam int IDXW = $clog2(NBUF),
  localparam int AW   = IDXW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_swap,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [31:0]        wdata,
  input  logic [AW-1:0]      rd_addr,
  output logic [31:0]        rdata,
  input  logic               done_valid,
  input  logic [IDXW-1:0]    done_idx,
  output logic [NBUF-1:0]    req_vec,
  input  logic [IDXW-1:0]    eng_idx,
  output logic [ID_BITS-1:0] eng_id,
  output logic [63:0]        eng_data
);
  logic [NBUF-1:0]              wr_hit;
  logic [NBUF-1:0]              done_hit;
  logic [NBUF-1:0][ID_BITS-1:0] ids;
  logic [NBUF-1:0][63:0]        datas;
  word_sel_e                    wr_sel;

  assign wr_sel = word_sel_e'(wr_addr[1:0]);

  for (genvar i = 0; i < NBUF; i++) begin : g_slot
    assign wr_hit[i]   = wr_en && (wr_addr[AW-1:2] == IDXW'(i));
    assign done_hit[i] = done_valid && (done_idx == IDXW'(i));

    can_txbox_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit[i]),
      .word_sel (wr_sel),
      .wdata    (wdata),
      .swap     (cfg_swap),
      .done_hit (done_hit[i]),
      .req_o    (req_vec[i]),
      .id_o     (ids[i]),
      .data_o   (datas[i])
    );
  end

  can_txbox_rdmux #(.NBUF(NBUF)) u_rdmux (
    .req      (req_vec),
    .ids      (ids),
    .datas    (datas),
    .swap     (cfg_swap),
    .rd_addr  (rd_addr),
    .eng_idx  (eng_idx),
    .rdata    (rdata),
    .eng_id   (eng_id),
    .eng_data (eng_data)
  );

  // R1: at most one new request per cycle
  a_r1_one_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(req_vec & ~$past(req_vec)) <= 1);
  // R9: the completed mailbox is idle afterwards
  a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !req_vec[$past(done_idx)]);
  // R10: flags only rise through a control write
  a_r10_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ((req_vec & ~$past(req_vec)) == '0));
endmodule

// File: tb/sim_can_txbox_bank.sv
`timescale 1ns/1ps
module sim_can_txbox_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_swap = 1'b0;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wdata = '0;
  logic [6:0]  rd_addr = '0;
  logic [31:0] rdata;
  logic        done_valid = 1'b0;
  logic [4:0]  done_idx = '0;
  logic [31:0] req_vec;
  logic [4:0]  eng_idx = '0;
  logic [28:0] eng_id;
  logic [63:0] eng_data;

  always #4 clk = ~clk;

  can_txbox_bank u0 (
    .clk(clk), .rst_n(rst_n), .cfg_swap(cfg_swap), .wr_en(wr_en), .wr_addr(wr_addr),
    .wdata(wdata), .rd_addr(rd_addr), .rdata(rdata), .done_valid(done_valid),
    .done_idx(done_idx), .req_vec(req_vec), .eng_idx(eng_idx), .eng_id(eng_id),
    .eng_data(eng_data)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural model: byte k of mailbox i kept in m_b[i][k-1]
  bit         m_req [32];
  bit [28:0]  m_id  [32];
  bit [7:0]   m_b   [32][8];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(int idx, int sel);
    logic [31:0] w;
    int base;
    w = '0;
    if (sel == 0) w = {31'b0, m_req[idx]};
    else if (sel == 1) w = {m_id[idx], 3'b000};
    else begin
      base = (sel == 2) ? 0 : 4;
      for (int k = 0; k < 4; k++) begin
        // lane 3 is bits [31:24]
        if (cfg_swap) w[8*k +: 8] = m_b[idx][base + k];
        else          w[8*(3-k) +: 8] = m_b[idx][base + k];
      end
    end
    return w;
  endfunction

  function automatic logic [63:0] model_payload(int idx);
    logic [63:0] p;
    for (int k = 0; k < 8; k++) p[8*(7-k) +: 8] = m_b[idx][k];
    return p;
  endfunction

  task automatic model_update();
    int idx, sel, base;
    bit [31:0] req_now;
    idx = int'(wr_addr[6:2]);
    sel = int'(wr_addr[1:0]);
    if (wr_en) begin
      if (sel == 0) begin
        if (wdata[0] && !(done_valid && int'(done_idx) == idx)) m_req[idx] = 1'b1;
      end else if (!m_req[idx]) begin
        if (sel == 1) m_id[idx] = wdata[31:3];
        else begin
          base = (sel == 2) ? 0 : 4;
          for (int k = 0; k < 4; k++) begin
            if (cfg_swap) m_b[idx][base + k] = wdata[8*k +: 8];
            else          m_b[idx][base + k] = wdata[8*(3-k) +: 8];
          end
        end
      end
    end
    if (done_valid) m_req[int'(done_idx)] = 1'b0;
    req_now = '0;
    for (int i = 0; i < 32; i++) req_now[i] = m_req[i];
  endtask

  function automatic logic [31:0] model_vec();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = m_req[i];
    return v;
  endfunction

  // One clock: model follows the edge, outputs compared on every cycle
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk("R2/R9 req_vec per-cycle", {32'b0, req_vec}, {32'b0, model_vec()});
    #1;
    chk("R11 eng_id per-cycle", {35'b0, eng_id}, {35'b0, m_id[int'(eng_idx)]});
    chk("R11 eng_data per-cycle", eng_data, model_payload(int'(eng_idx)));
    wr_en = 1'b0;
    done_valid = 1'b0;
    eng_idx = eng_idx + 5'd1;
  endtask

  task automatic wr(int idx, int sel, logic [31:0] d);
    wr_en = 1'b1;
    wr_addr = {5'(idx), 2'(sel)};
    wdata = d;
    step();
  endtask

  task automatic rd(string tag, int idx, int sel);
    rd_addr = {5'(idx), 2'(sel)};
    #1;
    chk(tag, {32'b0, rdata}, {32'b0, model_word(idx, sel)});
  endtask

  task automatic done(int idx);
    done_valid = 1'b1;
    done_idx = 5'(idx);
    step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 req_vec after reset", {32'b0, req_vec}, 64'd0);
    rd("R8 id reset", 7, 1);
    rd("R8 data reset", 7, 2);
    rd("R8 ctl reset", 0, 0);

    // R5 R6 R12: unswapped payload, reserved id bits written as 1
    wr(3, 1, 32'hABCD_EF07);
    rd("R5 id reserved bits read 0", 3, 1);
    chk("R5 id value", {32'b0, rdata}, {32'b0, 32'hABCD_EF00});
    wr(3, 2, 32'h1122_3344);
    wr(3, 3, 32'h5566_7788);
    rd("R6 high word swap0", 3, 2);
    rd("R12 low word swap0", 3, 3);
    eng_idx = 5'd3; #1;
    chk("R11 eng_data canonical swap0", eng_data, 64'h1122_3344_5566_7788);

    // R7: swapped writes, read back under both settings
    cfg_swap = 1'b1;
    wr(5, 2, 32'h4433_2211);
    wr(5, 3, 32'h8877_6655);
    rd("R7 high word swap1", 5, 2);
    chk("R7 high word value", {32'b0, rdata}, {32'b0, 32'h4433_2211});
    eng_idx = 5'd5; #1;
    chk("R11 eng_data canonical swap1", eng_data, 64'h1122_3344_5566_7788);
    cfg_swap = 1'b0;
    rd("R6 high word under swap0", 5, 2);
    chk("R6 byte1 on top", {32'b0, rdata}, {32'b0, 32'h1122_3344});
    rd("R6 low word under swap0", 5, 3);

    // R3: zero control write
    wr(3, 0, 32'hFFFF_FFFE);
    rd("R3 ctl after zero write", 3, 0);
    chk("R3 no request", {32'b0, req_vec}, 64'd0);

    // R2 then R4 lock
    wr(3, 0, 32'hFFFF_FFFF);
    rd("R2 ctl flag set", 3, 0);
    chk("R3 ctl upper bits zero", {32'b0, rdata}, 64'd1);
    wr(3, 1, 32'h0000_0008);
    wr(3, 2, 32'hDEAD_BEEF);
    wr(3, 3, 32'hCAFE_F00D);
    rd("R4 id frozen", 3, 1);
    rd("R4 high frozen", 3, 2);
    chk("R4 high value", {32'b0, rdata}, {32'b0, 32'h1122_3344});
    rd("R4 low frozen", 3, 3);
    wr(4, 2, 32'h0102_0304);
    rd("R4 other mailbox writable", 4, 2);

    // R9 clear, R10 idle completion
    done(7);
    chk("R10 idle completion", {32'b0, req_vec}, 64'h8);
    done(3);
    chk("R9 completion clears", {32'b0, req_vec}, 64'd0);
    wr(3, 2, 32'hDEAD_BEEF);
    rd("R4 writable after completion", 3, 2);

    // R9 collision: completion beats same-cycle set
    done_valid = 1'b1; done_idx = 5'd9;
    wr(9, 0, 32'h1);
    chk("R9 completion wins collision", {32'b0, req_vec}, 64'd0);

    // R10 isolation and R1 full range
    wr(0, 0, 32'h1);
    wr(31, 0, 32'h1);
    done(0);
    chk("R10 other flag kept", {32'b0, req_vec}, 64'h8000_0000);
    for (int i = 0; i < 32; i++) wr(i, 1, 32'(i * 32'h0101_0108));
    for (int i = 0; i < 32; i++) wr(i, 0, 32'h1);
    chk("R1 all flags set", {32'b0, req_vec}, 64'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) rd("R1 id per mailbox", i, 1);
    for (int i = 31; i >= 0; i--) done(i);
    chk("R1 all flags cleared", {32'b0, req_vec}, 64'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule